// File: doc/BRIEF.md
# Bus Turnaround Timeout Timer

This block watches the quiet interval between two phases of a full-speed serial bus transaction and flags a turnaround timeout when the expected packet never starts. An end-of-packet event arms it, but only when the phase code reports a gap that must be followed by a reply. One case is a setup or out token waiting for its data packet. The other is an in-data packet waiting for its handshake. Once armed, it counts bit-time strobes while the line stays idle.

Any activity on the line disarms the timer quietly. Activity means the line leaving idle or a start-of-packet detect. If the line is still idle when the count goes past the limit of sixteen bit times, the block raises a one-cycle timeout pulse and disarms. It stays disarmed until the next qualifying end-of-packet. Line decoding, the strobe generator and the error register that collects the pulse sit outside this block.

Top module: `bus_turnaround_timer`

## Requirements
- R1: After reset the timer is disarmed and `timeout_o` is 0.
- R2: An `eop_evt` cycle with `phase` = 2'd1 (token awaiting data) or `phase` = 2'd2 (in-data awaiting handshake) arms the timer with a count of zero.
- R3: An `eop_evt` cycle with `phase` = 2'd0 (no reply expected) or 2'd3 (other) leaves the timer disarmed, and stops a running count. No later strobe then produces a timeout.
- R4: Only cycles with `bit_tick` high advance the count. Cycles without a strobe leave it unchanged.
- R5: With the line idle throughout, the 17th counted strobe after the arming end-of-packet makes `timeout_o` high for exactly one cycle, in the clock cycle after that strobe. Sixteen strobes alone give no timeout.
- R6: While armed, a cycle with `line_idle` = 0 or `sop_det` = 1 disarms the timer and clears the count, without a timeout.
- R7: If activity and the strobe that would pass the limit fall in the same cycle, activity wins and no timeout is raised.
- R8: After a timeout the timer stays disarmed, so further strobes give no pulse until a qualifying `eop_evt`.
- R9: An `eop_evt` takes priority over everything else in its cycle. A qualifying one restarts the count from zero, even when the timer is already armed. A strobe in the same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| eop_evt | input | 1 | End-of-packet seen this cycle |
| line_idle | input | 1 | Line is in the idle state |
| sop_det | input | 1 | Start of packet detected |
| phase | input | 2 | Phase code of the packet just ended |
| timeout_o | output | 1 | One-cycle turnaround timeout pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is expiry and activity: the 17th strobe arrives together with a drop of `line_idle` or a start-of-packet detect, and the result must be no pulse and a disarmed timer. The second pair is arming and counting: an end-of-packet arrives together with a strobe, or while the count is mid-way, and the bench checks that the count restarts from zero. It does this by counting exactly 17 further strobes to the pulse. A behavioural model in the bench predicts `timeout_o` for every clock, and the output is compared with it on every cycle.

// File: rtl/btt_pkg.sv
package btt_pkg;

  typedef enum logic [1:0] {
    PH_NONE       = 2'd0,
    PH_AWAIT_DATA = 2'd1,
    PH_AWAIT_HS   = 2'd2,
    PH_OTHER      = 2'd3
  } phase_e;

  // True when the phase just ended must be answered by another packet.
  function automatic logic phase_arms(input logic [1:0] code);
    phase_e p;
    p = phase_e'(code);
    return (p == PH_AWAIT_DATA) || (p == PH_AWAIT_HS);
  endfunction

  // Line activity that ends a turnaround gap.
  function automatic logic line_active(input logic idle, input logic sop,
                                       input logic use_sop);
    return !idle || (use_sop && sop);
  endfunction

endpackage

// File: rtl/btt_arm_ctrl.sv
module btt_arm_ctrl
  import btt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eop_evt,
  input  logic [1:0] phase,
  input  logic       activity,
  input  logic       expire,
  output logic       armed,
  output logic       arm_evt
);

  logic armed_d;

  assign arm_evt = eop_evt && phase_arms(phase);

  always_comb begin
    armed_d = armed;
    if (eop_evt)                       armed_d = arm_evt;
    else if (armed && (activity || expire)) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armed_d;
  end

endmodule

// File: rtl/btt_tick_counter.sv
module btt_tick_counter #(
  parameter int LIMIT_BITS = 16,
  parameter int CNT_W      = $clog2(LIMIT_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);

  localparam logic [CNT_W-1:0] LIMIT_CNT = CNT_W'(LIMIT_BITS);

  assign at_limit = (count == LIMIT_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (advance) count <= count + 1'b1;
  end

endmodule

// File: rtl/btt_timeout_flag.sv
module btt_timeout_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  output logic pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= expire;
  end

endmodule

// File: rtl/bus_turnaround_timer.sv
module bus_turnaround_timer
  import btt_pkg::*;
#(
  parameter int LIMIT_BITS = 16,
  parameter bit SOP_ENDS   = 1'b1,
  parameter int CNT_W      = $clog2(LIMIT_BITS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       eop_evt,
  input  logic       line_idle,
  input  logic       sop_det,
  input  logic [1:0] phase,
  output logic       timeout_o
);

  // Named internal events, visible to the bound checker.
  logic             armed;
  logic             arm_evt;
  logic             activity;
  logic             counted_tick;
  logic             expire;
  logic             at_limit;
  logic             cnt_clear;
  logic [CNT_W-1:0] count;

  generate
    if (SOP_ENDS) begin : g_act_sop
      assign activity = line_active(line_idle, sop_det, 1'b1);
    end else begin : g_act_line
      assign activity = line_active(line_idle, sop_det, 1'b0);
    end
  endgenerate

  assign counted_tick = armed && !eop_evt && !activity && bit_tick;
  assign expire       = counted_tick && at_limit;
  assign cnt_clear    = eop_evt || !armed || activity || expire;

  btt_arm_ctrl u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .eop_evt  (eop_evt),
    .phase    (phase),
    .activity (activity),
    .expire   (expire),
    .armed    (armed),
    .arm_evt  (arm_evt)
  );

  btt_tick_counter #(.LIMIT_BITS(LIMIT_BITS), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .advance  (counted_tick),
    .count    (count),
    .at_limit (at_limit)
  );

  btt_timeout_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .pulse  (timeout_o)
  );

endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
  parameter int LIMIT_BITS = 16,
  parameter int CNT_W      = $clog2(LIMIT_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             eop_evt,
  input logic             arm_evt,
  input logic             activity,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic             timeout_o
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT_BITS);

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> (armed && count == '0));

  assert_no_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_evt && !arm_evt) |=> !armed);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !bit_tick && !eop_evt && !activity) |=> $stable(count));

  assert_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && bit_tick && !eop_evt && !activity && count == LIM) |=> timeout_o);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  assert_activity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && activity && !eop_evt) |=> (!armed && !timeout_o));

  assert_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !armed);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIM);

endmodule

bind bus_turnaround_timer btt_checker #(.LIMIT_BITS(LIMIT_BITS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .eop_evt   (eop_evt),
  .arm_evt   (arm_evt),
  .activity  (activity),
  .armed     (armed),
  .count     (count),
  .timeout_o (timeout_o)
);

// File: tb/bus_turnaround_timer_tb.sv
module bus_turnaround_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       eop_evt = 1'b0;
  logic       line_idle = 1'b1;
  logic       sop_det = 1'b0;
  logic [1:0] phase = 2'd0;
  logic       timeout_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  bit ref_armed = 1'b0;
  int ref_cnt   = 0;
  bit exp_to    = 1'b0;
  int pulses    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_turnaround_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .eop_evt   (eop_evt),
    .line_idle (line_idle),
    .sop_det   (sop_det),
    .phase     (phase),
    .timeout_o (timeout_o)
  );

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: timeout_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive after negedge, model at posedge, compare at next negedge.
  task automatic step(input string req, input bit tk, input bit eop,
                      input bit idle, input bit sop, input logic [1:0] ph);
    bit act;
    bit_tick = tk; eop_evt = eop; line_idle = idle; sop_det = sop; phase = ph;
    @(posedge clk);
    act = !idle || sop;
    exp_to = 1'b0;
    if (eop) begin
      ref_armed = (ph == 2'd1) || (ph == 2'd2);
      ref_cnt = 0;
    end else if (ref_armed) begin
      if (act) begin
        ref_armed = 1'b0; ref_cnt = 0;
      end else if (tk) begin
        if (ref_cnt + 1 > LIMIT) begin
          exp_to = 1'b1; ref_armed = 1'b0; ref_cnt = 0;
        end else ref_cnt++;
      end
    end
    @(negedge clk);
    if (timeout_o === 1'b1) pulses++;
    check(req, timeout_o, exp_to);
  endtask

  task automatic quiet_ticks(input string req, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(req, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0);
      for (int g = 0; g < gap; g++) step(req, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    end
  endtask

  task automatic count_pulses(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: pulse count %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    check("R1", timeout_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", timeout_o, 1'b0);

    // R2/R5: data-awaiting phase, ticks spaced by idle cycles (R4)
    p0 = pulses;
    step("R2", 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    quiet_ticks("R4", 16, 2);
    count_pulses("R5 sixteen ticks", pulses - p0, 0);
    quiet_ticks("R5", 1, 0);
    count_pulses("R5 seventeenth tick", pulses - p0, 1);

    // R8: no more pulses after timeout
    p0 = pulses;
    quiet_ticks("R8", 25, 0);
    count_pulses("R8", pulses - p0, 0);

    // R2: handshake-awaiting phase also arms
    p0 = pulses;
    step("R2", 1'b0, 1'b1, 1'b1, 1'b0, 2'd2);
    quiet_ticks("R2", 17, 1);
    count_pulses("R2 in-data phase", pulses - p0, 1);

    // R3: phases 0 and 3 do not arm; also stop running count
    p0 = pulses;
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 2'd0);
    quiet_ticks("R3", 20, 0);
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 2'd3);
    quiet_ticks("R3", 20, 0);
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    quiet_ticks("R3", 10, 0);
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 2'd0);
    quiet_ticks("R3", 20, 0);
    count_pulses("R3", pulses - p0, 0);

    // R6: line leaves idle mid-count, then by sop_det
    p0 = pulses;
    step("R6", 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    quiet_ticks("R6", 10, 0);
    step("R6", 1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
    quiet_ticks("R6", 20, 0);
    step("R6", 1'b0, 1'b1, 1'b1, 1'b0, 2'd2);
    quiet_ticks("R6", 5, 0);
    step("R6", 1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
    quiet_ticks("R6", 20, 0);
    count_pulses("R6", pulses - p0, 0);

    // R7: limit-passing tick coincides with activity
    p0 = pulses;
    step("R7", 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    quiet_ticks("R7", 16, 0);
    step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    quiet_ticks("R7", 20, 0);
    step("R7", 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    quiet_ticks("R7", 16, 0);
    step("R7", 1'b1, 1'b0, 1'b1, 1'b1, 2'd0);
    count_pulses("R7", pulses - p0, 0);

    // R9: re-arm mid-count with tick in same cycle
    p0 = pulses;
    step("R9", 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    quiet_ticks("R9", 12, 0);
    step("R9", 1'b1, 1'b1, 1'b0, 1'b0, 2'd2);
    quiet_ticks("R9", 16, 0);
    count_pulses("R9 restart", pulses - p0, 0);
    quiet_ticks("R9", 1, 0);
    count_pulses("R9 restart", pulses - p0, 1);

    // R1: reset mid-count clears state
    p0 = pulses;
    step("R1", 1'b0, 1'b1, 1'b1, 1'b0, 2'd1);
    quiet_ticks("R1", 14, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", timeout_o, 1'b0);
    rst_n = 1'b1;
    ref_armed = 1'b0; ref_cnt = 0;
    quiet_ticks("R1", 10, 0);
    count_pulses("R1", pulses - p0, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule